// File: doc/BRIEF.md
# Serial Configuration ROM Autoload Sequencer

This block runs by itself after reset. It drives a three-wire serial configuration ROM through four plain pins: select, serial clock, command out and data in. From that ROM it recovers a 48-bit station address and decides whether the ROM contents can be trusted. The sequence has three steps:

- It works out how many address bits the ROM expects.
- It reads the 64 sixteen-bit words in ascending order and keeps a wrapping 16-bit sum of them.
- It compares the final sum with a fixed signature.

The outputs are the address, a done flag and a checksum-ok flag. When the signature does not match, the address output is forced to zero.

Every pin phase lasts `PHASE_CLKS` system clocks. The integrator picks this value so that one phase is at least 1 µs, which keeps the serial clock inside the ROM's timing limits. A one-cycle `start` pulse repeats the whole sequence from the width probe onward.

Top module: `eeprom_autoload`

## Requirements
- R1: After reset, and again after `start`, the first ROM access reads location 0 with 6 address bits. Every access shifts out a 13-bit command, MSB first. The command is zero-padded at the top, then has a 1 start bit, then the read opcode bits 1 and 0, then the address bits MSB first. With 6 address bits this gives 4 leading zeros; with 8 address bits it gives 2.
- R2: For each command bit, `rom_mosi` takes the bit while `rom_clk` is low, and then `rom_clk` rises with `rom_mosi` held. `rom_mosi` never changes while `rom_clk` is high. Every high phase of `rom_clk` lasts at least `PHASE_CLKS` cycles.
- R3: After the command, 16 data bits are clocked in MSB first. `rom_miso` is sampled at the end of each high phase of `rom_clk`, and `rom_clk` then returns low.
- R4: `rom_sel` is low for at least one phase before each access, high for the whole access, and low afterwards. `rom_clk` is high only while `rom_sel` is high.
- R5: If the probe word is 0xFFFF, all later accesses use 8 address bits. Otherwise they use 6.
- R6: After the probe, exactly 64 accesses follow, to locations 0 through 63 in that order. That is 65 accesses per sequence.
- R7: The address byte at bits [8k+7:8k] is byte k. Byte 0 is the low byte of word 0, byte 1 the high byte of word 0, and so on up to byte 5, the high byte of word 2. So `station_addr` equals {word2, word1, word0}.
- R8: If the 16-bit wrapping sum of all 64 words equals 0xBABA, `checksum_ok` is 1 and the address is presented. Otherwise `checksum_ok` is 0 and `station_addr` is 0.
- R9: `done`, `checksum_ok` and `station_addr` are 0 during reset and until the decision is made. Once `done` rises it stays high, with the outputs unchanged, until `start`.
- R10: `start` clears `done` on the next cycle and restarts the whole sequence with a new probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that restarts the whole sequence |
| rom_miso | input | 1 | Serial data returned by the ROM |
| rom_sel | output | 1 | ROM select, high during an access |
| rom_clk | output | 1 | Serial clock to the ROM |
| rom_mosi | output | 1 | Serial command bits to the ROM |
| station_addr | output | 48 | Recovered station address, zero unless the checksum matched |
| done | output | 1 | The checksum decision has been made |
| checksum_ok | output | 1 | The word sum matched the signature |

## Verification
Some pin and output rules are checked by the assertions on every cycle:

- `rom_clk` is high only under `rom_sel`.
- `rom_mosi` holds still while `rom_clk` is high.
- Each high clock phase lasts at least `PHASE_CLKS` cycles.
- `done` is sticky, and `start` clears it.
- The address is zero whenever `done` is high without a checksum match.

Other behaviour only shows in the bench's scenarios, which run against a behavioural ROM model with 6-bit and with 8-bit addressing:

- The width the probe selects, visible in the number of leading zeros of each command.
- The in-order read of locations 0 to 63.
- The byte order of the address.
- The sum that wraps on overflow.
- The zeroing of the address on a corrupted image.

// File: rtl/eal_pkg.sv
package eal_pkg;
  // start bit followed by the two read opcode bits
  localparam logic [2:0] READ_LEAD = 3'b110;

  typedef enum logic [2:0] {
    F_IDLE, F_LEAD, F_CLO, F_CHI, F_DLO, F_DHI, F_TAIL
  } frame_st_t;

  typedef enum logic [2:0] {
    Q_PROBE_GO, Q_PROBE_WAIT, Q_READ_GO, Q_READ_WAIT, Q_DECIDE, Q_HOLD
  } seq_st_t;
endpackage

// File: rtl/eal_tick.sv
module eal_tick #(
  parameter int PHASE_CLKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(PHASE_CLKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(PHASE_CLKS - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/eal_frame.sv
module eal_frame
  import eal_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CMD_W     = 13,
  parameter int NARROW_AW = 6,
  parameter int WIDE_AW   = 8,
  parameter int LOC_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  input  logic              go,
  input  logic              wide,
  input  logic [LOC_W-1:0]  loc,
  input  logic              ser_in,
  output logic              sel_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              fin,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2((CMD_W > WORD_W) ? CMD_W : WORD_W);

  frame_st_t        st;
  logic [CMD_W-1:0] cmd_sr;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmd_narrow, cmd_wide;

  assign cmd_narrow = (CMD_W'(READ_LEAD) << NARROW_AW) | CMD_W'(loc);
  assign cmd_wide   = (CMD_W'(READ_LEAD) << WIDE_AW)   | CMD_W'(loc);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st     <= F_IDLE;
      cmd_sr <= '0;
      cnt    <= '0;
      word   <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        F_IDLE: if (go) begin
          cmd_sr <= wide ? cmd_wide : cmd_narrow;
          cnt    <= CNT_W'(CMD_W - 1);
          st     <= F_LEAD;
        end
        F_LEAD: if (tick) st <= F_CLO;
        F_CLO:  if (tick) st <= F_CHI;
        F_CHI: if (tick) begin
          if (cnt == '0) begin
            cnt <= CNT_W'(WORD_W - 1);
            st  <= F_DLO;
          end else begin
            cnt    <= cnt - 1'b1;
            cmd_sr <= {cmd_sr[CMD_W-2:0], 1'b0};
            st     <= F_CLO;
          end
        end
        F_DLO: if (tick) st <= F_DHI;
        F_DHI: if (tick) begin
          word <= {word[WORD_W-2:0], ser_in};
          if (cnt == '0) st <= F_TAIL;
          else begin
            cnt <= cnt - 1'b1;
            st  <= F_DLO;
          end
        end
        F_TAIL: if (tick) begin
          st  <= F_IDLE;
          fin <= 1'b1;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  // registered pin drivers, one cycle behind the state decode
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sel_o  <= 1'b0;
      sclk_o <= 1'b0;
      sdo_o  <= 1'b0;
    end else begin
      sel_o  <= (st == F_CLO) || (st == F_CHI) || (st == F_DLO) || (st == F_DHI);
      sclk_o <= (st == F_CHI) || (st == F_DHI);
      sdo_o  <= ((st == F_CLO) || (st == F_CHI)) && cmd_sr[CMD_W-1];
    end
  end
endmodule

// File: rtl/eeprom_autoload.sv
module eeprom_autoload
  import eal_pkg::*;
#(
  parameter int          PHASE_CLKS = 100,
  parameter int          WORD_W     = 16,
  parameter int          NUM_WORDS  = 64,
  parameter int          CMD_W      = 13,
  parameter int          NARROW_AW  = 6,
  parameter int          WIDE_AW    = 8,
  parameter int          MAC_WORDS  = 3,
  parameter logic [15:0] SIGNATURE  = 16'hBABA
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        rom_miso,
  output logic        rom_sel,
  output logic        rom_clk,
  output logic        rom_mosi,
  output logic [47:0] station_addr,
  output logic        done,
  output logic        checksum_ok
);
  localparam int LOC_W    = $clog2(NUM_WORDS);
  localparam int MAC_BITS = MAC_WORDS * WORD_W;

  logic              tick, f_go, f_fin;
  logic [WORD_W-1:0] f_word;
  seq_st_t           st;
  logic              wide_q;
  logic [LOC_W-1:0]  loc_q;
  logic [WORD_W-1:0] sum_q;
  logic [MAC_BITS-1:0] raw_q;

  eal_tick #(.PHASE_CLKS(PHASE_CLKS)) u_tick (
    .clk(clk), .rst(rst), .clr(start), .tick(tick)
  );

  assign f_go = (st == Q_PROBE_GO) || (st == Q_READ_GO);

  eal_frame #(
    .WORD_W(WORD_W), .CMD_W(CMD_W), .NARROW_AW(NARROW_AW),
    .WIDE_AW(WIDE_AW), .LOC_W(LOC_W)
  ) u_frame (
    .clk(clk), .rst(rst), .clr(start), .tick(tick), .go(f_go),
    .wide(wide_q), .loc(loc_q), .ser_in(rom_miso),
    .sel_o(rom_sel), .sclk_o(rom_clk), .sdo_o(rom_mosi),
    .fin(f_fin), .word(f_word)
  );

  always_ff @(posedge clk) begin
    if (rst || start) begin
      st           <= Q_PROBE_GO;
      wide_q       <= 1'b0;
      loc_q        <= '0;
      sum_q        <= '0;
      raw_q        <= '0;
      done         <= 1'b0;
      checksum_ok  <= 1'b0;
      station_addr <= '0;
    end else begin
      case (st)
        Q_PROBE_GO:   st <= Q_PROBE_WAIT;
        Q_PROBE_WAIT: if (f_fin) begin
          wide_q <= (f_word == '1);
          loc_q  <= '0;
          st     <= Q_READ_GO;
        end
        Q_READ_GO:    st <= Q_READ_WAIT;
        Q_READ_WAIT: if (f_fin) begin
          sum_q <= sum_q + f_word;
          for (int k = 0; k < MAC_WORDS; k++)
            if (loc_q == LOC_W'(k)) raw_q[k*WORD_W +: WORD_W] <= f_word;
          if (loc_q == LOC_W'(NUM_WORDS - 1)) st <= Q_DECIDE;
          else begin
            loc_q <= loc_q + 1'b1;
            st    <= Q_READ_GO;
          end
        end
        Q_DECIDE: begin
          done         <= 1'b1;
          checksum_ok  <= (sum_q == SIGNATURE);
          station_addr <= (sum_q == SIGNATURE) ? 48'(raw_q) : '0;
          st           <= Q_HOLD;
        end
        Q_HOLD:  st <= Q_HOLD;
        default: st <= Q_PROBE_GO;
      endcase
    end
  end
endmodule

// File: rtl/eal_checker.sv
module eal_checker #(
  parameter int PHASE_CLKS = 100,
  parameter int ADDR_BITS  = 48
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 rom_sel,
  input logic                 rom_clk,
  input logic                 rom_mosi,
  input logic [ADDR_BITS-1:0] station_addr,
  input logic                 done,
  input logic                 checksum_ok
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (rom_clk) hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  p_clk_in_sel_r4: assert property (@(posedge clk) disable iff (rst)
    rom_clk |-> rom_sel);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (rom_clk && $past(rom_clk)) |-> $stable(rom_mosi));

  p_phase_len_r2: assert property (@(posedge clk) disable iff (rst)
    (!rom_clk && $past(rom_clk)) |-> (hi_cnt >= 16'(PHASE_CLKS)));

  p_ok_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
    checksum_ok |-> done);

  p_bad_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !checksum_ok) |-> (station_addr == '0));

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(station_addr)));

  p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);
endmodule

bind eeprom_autoload eal_checker #(
  .PHASE_CLKS(PHASE_CLKS), .ADDR_BITS(48)
) u_eal_chk (
  .clk(clk), .rst(rst), .start(start), .rom_sel(rom_sel),
  .rom_clk(rom_clk), .rom_mosi(rom_mosi), .station_addr(station_addr),
  .done(done), .checksum_ok(checksum_ok)
);

// File: tb/tb_eeprom_autoload.sv
module tb_eeprom_autoload;
  localparam int PHASE = 4;
  localparam logic [15:0] SIG = 16'hBABA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rom_miso;
  logic rom_sel, rom_clk, rom_mosi;
  logic [47:0] station_addr;
  logic done, checksum_ok;

  always #5 clk = ~clk;

  eeprom_autoload #(.PHASE_CLKS(PHASE)) dut (
    .clk(clk), .rst(rst), .start(start), .rom_miso(rom_miso),
    .rom_sel(rom_sel), .rom_clk(rom_clk), .rom_mosi(rom_mosi),
    .station_addr(station_addr), .done(done), .checksum_ok(checksum_ok)
  );

  int n_run = 0;
  int n_fail = 0;

  // ---------------- behavioural ROM model ----------------
  logic [15:0] mem [64];
  int   model_aw = 6;
  logic mclr = 1'b1;
  logic m_do = 1'b1;
  assign rom_miso = m_do;

  int frames = 0, order_err = 0, lead_err = 0, op_err = 0;
  bit started = 0, outing = 0;
  int cnt = 0, lead0 = 0, oidx = 0;
  logic [15:0] cmd_sr = '0, word = '0;
  logic cs_q = 0, sk_q = 0;

  always @(posedge clk) begin
    if (mclr) begin
      frames = 0; order_err = 0; lead_err = 0; op_err = 0;
      started = 0; outing = 0; cnt = 0; lead0 = 0; oidx = 0;
      m_do <= 1'b1;
    end else if (rom_sel && !cs_q) begin
      started = 0; outing = 0; cnt = 0; lead0 = 0; oidx = 0;
      m_do <= 1'b1;
    end else if (rom_sel && rom_clk && !sk_q) begin
      if (!started) begin
        if (rom_mosi) started = 1; else lead0++;
      end else if (cnt < 2 + model_aw) begin
        cmd_sr = {cmd_sr[14:0], rom_mosi};
        cnt++;
        if (cnt == 2 + model_aw) begin
          int a, exp_a;
          a = int'(cmd_sr & ((16'd1 << model_aw) - 16'd1));
          exp_a = (frames == 0) ? 0 : frames - 1;
          if (a != exp_a) order_err++;
          if (((cmd_sr >> model_aw) & 16'd3) != 16'd2) op_err++;
          if (lead0 != ((frames == 0) ? 4 : 10 - model_aw)) lead_err++;
          word = mem[a % 64];
          outing = 1; oidx = 0;
          frames++;
        end
      end else if (outing && oidx < 16) begin
        m_do <= word[15 - oidx];
        oidx++;
      end
    end
    cs_q = rom_sel;
    sk_q = rom_clk;
  end

  // ---------------- pin monitor ----------------
  int hi_run = 0, lo_run = 0, ph_err = 0, di_err = 0, skcs_err = 0, cslead_err = 0;
  logic mon_sk_q = 0, mon_cs_q = 0, mon_di_q = 0;
  always @(posedge clk) begin
    if (!rst) begin
      if (rom_clk) hi_run++;
      else begin
        if (mon_sk_q && hi_run < PHASE) ph_err++;
        hi_run = 0;
      end
      if (rom_clk && mon_sk_q && rom_mosi != mon_di_q) di_err++;
      if (rom_clk && !rom_sel) skcs_err++;
      if (!rom_sel) lo_run++;
      else begin
        if (!mon_cs_q && lo_run < PHASE) cslead_err++;
        lo_run = 0;
      end
    end
    mon_sk_q = rom_clk;
    mon_cs_q = rom_sel;
    mon_di_q = rom_mosi;
  end

  // ---------------- helpers ----------------
  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] w0, input logic [15:0] w1,
                       input logic [15:0] w2, input bit corrupt);
    logic [15:0] s;
    mem[0] = w0; mem[1] = w1; mem[2] = w2;
    for (int i = 3; i < 63; i++) mem[i] = 16'h3C5A + 16'(i) * 16'h0101;
    s = '0;
    for (int i = 0; i < 63; i++) s = s + mem[i];
    mem[63] = SIG - s + (corrupt ? 16'd1 : 16'd0);
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 40000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual done=0 expected done=1");
    end
  endtask

  task automatic check_run(input string tag, input bit exp_ok, input logic [47:0] exp_addr);
    check({tag, " R9 done"}, 64'(done), 64'd1);
    check({tag, " R8 checksum_ok"}, 64'(checksum_ok), 64'(exp_ok));
    check({tag, " R3 R7 R8 station_addr"}, 64'(station_addr), 64'(exp_addr));
    check({tag, " R6 access count"}, 64'(frames), 64'd65);
    check({tag, " R6 location order errors"}, 64'(order_err), 64'd0);
    check({tag, " R1 R5 leading-zero errors"}, 64'(lead_err), 64'd0);
    check({tag, " R1 opcode errors"}, 64'(op_err), 64'd0);
  endtask

  task automatic restart();
    @(negedge clk);
    mclr = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 done cleared after start", 64'(done), 64'd0);
    mclr = 1'b0;
  endtask

  initial begin
    // run 1: 6-bit ROM, good image
    build(16'h1234, 16'h5678, 16'h9ABC, 1'b0);
    model_aw = 6;
    repeat (4) @(negedge clk);
    check("R9 reset done", 64'(done), 64'd0);
    check("R9 reset checksum_ok", 64'(checksum_ok), 64'd0);
    check("R9 reset station_addr", 64'(station_addr), 64'd0);
    check("R4 reset rom_sel", 64'(rom_sel), 64'd0);
    rst = 1'b0;
    mclr = 1'b0;
    wait_done();
    check_run("narrow-good", 1'b1, {16'h9ABC, 16'h5678, 16'h1234});
    repeat (60) @(negedge clk);
    check("R9 done held", 64'(done), 64'd1);
    check("R9 addr held", 64'(station_addr), 64'({16'h9ABC, 16'h5678, 16'h1234}));

    // run 2: same ROM width, corrupted sum
    build(16'h1234, 16'h5678, 16'h9ABC, 1'b1);
    restart();
    wait_done();
    check_run("narrow-bad", 1'b0, 48'd0);

    // run 3: 8-bit ROM; a 6-bit probe reads back all ones
    build(16'hFFFD, 16'h5544, 16'h7766, 1'b0);
    model_aw = 8;
    restart();
    wait_done();
    check_run("wide-good", 1'b1, {16'h7766, 16'h5544, 16'hFFFD});

    // run 4: 8-bit ROM, corrupted sum
    build(16'hFFFE, 16'h0102, 16'h0304, 1'b1);
    restart();
    wait_done();
    check_run("wide-bad", 1'b0, 48'd0);

    check("R2 short clock-high phases", 64'(ph_err), 64'd0);
    check("R2 mosi change while clock high", 64'(di_err), 64'd0);
    check("R4 clock high without select", 64'(skcs_err), 64'd0);
    check("R4 short select-low gap", 64'(cslead_err), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule